// File: doc/BRIEF.md
# Reference-Clock Frequency Detector

This block works out which of three nominal system clock rates (19.2 MHz, 20 MHz or 27 MHz) is driving it. The slow 32 kHz reference is brought into the system clock domain, and its rising edges act as capture events on a free-running up-counter. The number of system clock cycles between consecutive captures is one reference period, counted in system cycles. These differences are summed over eight periods and divided by eight, which averages out edge jitter. The mean is then sorted into a frequency code.

Software or a boot sequencer pulses `start` to begin a measurement. The result appears together with a one-cycle `meas_valid` strobe. Two things give the unknown code: a mean that lies outside every window, or a reference that stops toggling. The result is a status strobe with no ready input, so there is no back-pressure. A consumer that wants the result must capture it in the cycle the strobe is high. A new `start` at any time abandons any measurement in progress and begins a fresh one.

Top module: `clk_freq_sense`

## Requirements
- R1: After reset, `meas_valid` is 0, `freq_code` is 0 and `meas_count` is 0.
- R2: After `start`, the first synchronised rising edge of `ref_in` arms the counter. The differences between the next eight consecutive edges are summed. `meas_count` reports the sum divided by eight and truncated, so a steady reference of P system cycles gives P.
- R3: The codes are: 1 for a mean in 574..597 (19.2 MHz), 2 for 598..716 (20 MHz) and 3 for 717..930 (27 MHz).
- R4: A mean below 574 or at or above 931 gives code 0 (unknown). The mean is still reported on `meas_count`.
- R5: If no reference edge arrives within 2048 system cycles of `start` or of the previous edge, the measurement ends with code 0 and `meas_count` equal to 0.
- R6: `meas_valid` is high for exactly one cycle per completed measurement. It never rises without a preceding `start`.
- R7: A `start` during a measurement discards that measurement. Exactly one result follows, and it comes from the new run.
- R8: When periods alternate between P-1 and P+1 cycles, the averaged result is P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock being identified |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Asynchronous 32 kHz reference |
| start | input | 1 | One-cycle pulse that begins a measurement |
| meas_count | output | 12 | Mean system cycles per reference period |
| freq_code | output | 2 | 0 unknown, 1 19.2 MHz, 2 20 MHz, 3 27 MHz |
| meas_valid | output | 1 | One-cycle result strobe |

## Verification
The bench places periods on both sides of every window edge: 573/574, 597/598, 716/717 and 930/931. A design with an off-by-one comparison would give the neighbouring code at one of these values. An alternating-period run catches two faults: a design that averages the wrong number of periods, or that measures from the arming edge, reports a mean other than P. A stopped reference must yield a timeout result rather than a hang. A restart in mid-measurement must produce a single strobe. A design that fails to abandon the first run would emit an extra or early strobe, and the monitor flags that as unexpected.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    FC_UNKNOWN = 2'd0,
    FC_19M2    = 2'd1,
    FC_20M     = 2'd2,
    FC_27M     = 2'd3
  } fcode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ARM  = 2'd1,
    S_RUN  = 2'd2
  } mstate_e;
endpackage

// File: rtl/cfs_ref_sync.sv
module cfs_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  output logic ref_rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ref_async};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign ref_rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cfs_period_acc.sv
module cfs_period_acc
  import cfs_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int N_PER   = 8,
  parameter int TIMEOUT = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ref_rise,
  output logic             done,
  output logic             timed_out,
  output logic [CNT_W-1:0] mean
);
  localparam int LOG2N = $clog2(N_PER);
  localparam int ACC_W = CNT_W + LOG2N;
  localparam int TW    = $clog2(TIMEOUT + 1);
  localparam int PW    = LOG2N + 1;

  mstate_e          state;
  logic [CNT_W-1:0] free_cnt;
  logic [CNT_W-1:0] last_cap;
  logic [ACC_W-1:0] acc;
  logic [PW-1:0]    nper;
  logic [TW-1:0]    idle_cnt;
  logic [CNT_W-1:0] diff;
  logic [ACC_W-1:0] acc_next;
  logic             idle_hit;

  assign diff     = free_cnt - last_cap;
  assign acc_next = acc + ACC_W'(diff);
  assign idle_hit = (idle_cnt == TW'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) free_cnt <= '0;
    else        free_cnt <= free_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      last_cap  <= '0;
      acc       <= '0;
      nper      <= '0;
      idle_cnt  <= '0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      mean      <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state    <= S_ARM;
        acc      <= '0;
        nper     <= '0;
        idle_cnt <= '0;
      end else begin
        case (state)
          S_ARM: begin
            if (ref_rise) begin
              last_cap <= free_cnt;
              idle_cnt <= '0;
              state    <= S_RUN;
            end else if (idle_hit) begin
              done      <= 1'b1;
              timed_out <= 1'b1;
              mean      <= '0;
              state     <= S_IDLE;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
          S_RUN: begin
            if (ref_rise) begin
              last_cap <= free_cnt;
              idle_cnt <= '0;
              acc      <= acc_next;
              if (nper == PW'(N_PER - 1)) begin
                done      <= 1'b1;
                timed_out <= 1'b0;
                mean      <= acc_next[ACC_W-1:LOG2N];
                state     <= S_IDLE;
              end else begin
                nper <= nper + 1'b1;
              end
            end else if (idle_hit) begin
              done      <= 1'b1;
              timed_out <= 1'b1;
              mean      <= '0;
              state     <= S_IDLE;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_NPER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN) |-> (nper < PW'(N_PER))); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == S_IDLE)); // R6
endmodule

// File: rtl/cfs_classify.sv
module cfs_classify
  import cfs_pkg::*;
#(
  parameter int W     = 12,
  parameter int LO    = 574,
  parameter int MID_A = 598,
  parameter int MID_B = 717,
  parameter int HI    = 931
) (
  input  logic [W-1:0] cnt,
  output fcode_e       code
);
  always_comb begin
    if (cnt < W'(LO) || cnt >= W'(HI)) code = FC_UNKNOWN;
    else if (cnt < W'(MID_A))          code = FC_19M2;
    else if (cnt < W'(MID_B))          code = FC_20M;
    else                               code = FC_27M;
  end
endmodule

// File: rtl/clk_freq_sense.sv
module clk_freq_sense
  import cfs_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int N_PER   = 8,
  parameter int TIMEOUT = 2048,
  parameter int LO      = 574,
  parameter int MID_A   = 598,
  parameter int MID_B   = 717,
  parameter int HI      = 931
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             start,
  output logic [CNT_W-1:0] meas_count,
  output logic [1:0]       freq_code,
  output logic             meas_valid
);
  logic             ref_rise;
  logic             acc_done;
  logic             acc_tmo;
  logic [CNT_W-1:0] acc_mean;
  fcode_e           cls_code;

  cfs_ref_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_async(ref_in), .ref_rise(ref_rise)
  );

  cfs_period_acc #(.CNT_W(CNT_W), .N_PER(N_PER), .TIMEOUT(TIMEOUT)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_rise(ref_rise),
    .done(acc_done), .timed_out(acc_tmo), .mean(acc_mean)
  );

  cfs_classify #(.W(CNT_W), .LO(LO), .MID_A(MID_A), .MID_B(MID_B), .HI(HI)) u_cls (
    .cnt(acc_mean), .code(cls_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas_valid <= 1'b0;
      meas_count <= '0;
      freq_code  <= FC_UNKNOWN;
    end else begin
      meas_valid <= acc_done;
      if (acc_done) begin
        meas_count <= acc_tmo ? '0 : acc_mean;
        freq_code  <= acc_tmo ? FC_UNKNOWN : cls_code;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> !meas_valid); // R6
  AST_KNOWN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && freq_code != FC_UNKNOWN) |->
      (meas_count >= CNT_W'(LO) && meas_count < CNT_W'(HI))); // R3
  AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && meas_count == '0) |-> (freq_code == FC_UNKNOWN)); // R5
endmodule

// File: tb/test_clk_freq_sense.sv
module test_clk_freq_sense;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_in = 1'b0;
  logic        start = 1'b0;
  logic [11:0] meas_count;
  logic [1:0]  freq_code;
  logic        meas_valid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int valid_seen = 0;
  int pushed = 0;

  int    q_cnt[$];
  int    q_code[$];
  string q_tag[$];

  int ref_period = 0;
  bit ref_jitter = 0;
  int cur_period = 0;
  int phase = 0;
  bit jit_flip = 0;

  always #5 clk = ~clk;

  clk_freq_sense i_clk_freq_sense (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .start(start),
    .meas_count(meas_count), .freq_code(freq_code), .meas_valid(meas_valid)
  );

  // reference generator: period expressed in system cycles
  always @(negedge clk) begin
    if (ref_period == 0 && cur_period == 0) begin
      ref_in <= 1'b0;
    end else begin
      phase = phase + 1;
      if (phase >= cur_period) begin
        phase = 0;
        if (ref_period == 0) begin
          cur_period = 0;
          ref_in <= 1'b0;
        end else begin
          jit_flip = ~jit_flip;
          cur_period = ref_jitter ? (jit_flip ? ref_period - 1 : ref_period + 1) : ref_period;
          ref_in <= 1'b1;
        end
      end else if (phase == cur_period / 2) begin
        ref_in <= 1'b0;
      end
    end
  end

  function automatic int exp_code(int c);
    if (c < 574 || c >= 931) return 0;
    if (c < 598) return 1;
    if (c < 717) return 2;
    return 3;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic measure(int p, bit jit, string tag);
    ref_period = p;
    ref_jitter = jit;
    if (cur_period == 0) begin cur_period = p; phase = p - 1; end
    repeat (4) @(negedge clk);
    q_cnt.push_back(p);
    q_code.push_back(exp_code(p));
    q_tag.push_back(tag);
    pushed++;
    pulse_start();
    while (q_cnt.size() != 0) @(negedge clk);
  endtask

  // monitor: compare each strobe with the next expected item
  always @(negedge clk) begin
    if (rst_n && meas_valid) begin
      valid_seen++;
      if (q_cnt.size() == 0) begin
        checks++; failures++;
        $display("FAIL R6 unexpected strobe actual=1 expected=0");
      end else begin
        int ec, ek;
        string t;
        ec = q_cnt.pop_front();
        ek = q_code.pop_front();
        t  = q_tag.pop_front();
        check({t, " count"}, int'(meas_count), ec);
        check({t, " code"}, int'(freq_code), ek);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid", int'(meas_valid), 0);
    check("R1 code", int'(freq_code), 0);
    check("R1 count", int'(meas_count), 0);

    measure(586, 0, "R2 R3 19.2MHz");
    measure(610, 0, "R2 R3 20MHz");
    measure(824, 0, "R2 R3 27MHz");
    measure(573, 0, "R4 below low bound");
    measure(574, 0, "R3 low bound");
    measure(597, 0, "R3 top of 19.2 window");
    measure(598, 0, "R3 bottom of 20 window");
    measure(716, 0, "R3 top of 20 window");
    measure(717, 0, "R3 bottom of 27 window");
    measure(930, 0, "R3 top of 27 window");
    measure(931, 0, "R4 at high bound");
    measure(610, 1, "R8 jittered 20MHz");

    // R7: restart mid-measurement, only one result expected
    ref_period = 824; ref_jitter = 0;
    repeat (4) @(negedge clk);
    pulse_start();
    repeat (3 * 824) @(negedge clk);
    q_cnt.push_back(824); q_code.push_back(3); q_tag.push_back("R7 restarted run");
    pushed++;
    pulse_start();
    while (q_cnt.size() != 0) @(negedge clk);

    // R5: stopped reference
    ref_period = 0;
    repeat (1000) @(negedge clk);
    q_cnt.push_back(0); q_code.push_back(0); q_tag.push_back("R5 timeout");
    pushed++;
    pulse_start();
    while (q_cnt.size() != 0) @(negedge clk);

    // R6: no strobe without start, even with the reference running
    ref_period = 610; cur_period = 610; phase = 0;
    repeat (3000) @(negedge clk);
    check("R6 strobes per start", valid_seen, pushed);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule